// File: doc/BRIEF.md
# Twin-Predicated Element Move Engine

This engine copies elements from a source register group to a destination register group one element per clock. Each side has its own predicate mask and its own zeroing flag, and each side is flagged as a vector or a scalar. The source and destination element indices advance independently. A side that is a vector with zeroing off passes over the positions its own mask disables. Each active step drives a read of the source register and, where the rules call for it, a write of either the source value or zero to the destination register.

A move is launched by a one-cycle `start` pulse that captures the whole configuration. The engine stays `busy` while it walks the elements and raises `done` in its final busy cycle. The register file read is combinational: `rd_data` must answer `rd_addr` in the same cycle. A write presented on `wr_en`/`wr_addr`/`wr_data` is meant to be committed at the next rising edge, so the next step's read already sees it. Register numbers wrap modulo the register count. A length above `MAX_VL` is treated as `MAX_VL`.

Top module: `tpm_move_engine`

## Requirements
- R1: After reset, and whenever no move is in progress, `busy`, `done`, `rd_en` and `wr_en` are low.
- R2: With a vector source and source zeroing off, the source index moves forward past every position whose source mask bit (bit k of `src_mask` for element k) is 0 before the element is read.
- R3: With a vector destination and destination zeroing off, the destination index moves forward past every position whose destination mask bit is 0, so those registers are never written.
- R4: When the destination mask bit of the current destination element is 1, register `dst_base + j` receives the value of register `src_base + i`, with the source zeroing exception of R6.
- R5: When the destination mask bit is 0 and destination zeroing is on, register `dst_base + j` receives zero.
- R6: When source zeroing is on and the current source mask bit is 0, that step supplies zero as its data and the source index is not moved past that position.
- R7: After each step, the source index advances by one only for a vector source and the destination index only for a vector destination; a scalar source always reads `src_base`.
- R8: With a scalar destination, the move performs exactly one step (one write or none) and then ends.
- R9: The move ends when either index reaches `vl`; with `vl` = 0 nothing is written, skipping never goes beyond element `vl-1`, and no read or write touches an element at or above `vl`.
- R10: A `start` pulse that arrives while `busy` is high is ignored and does not alter the move in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse; captures the configuration when idle |
| src_base | input | REG_AW | First source register number |
| dst_base | input | REG_AW | First destination register number |
| src_vec | input | 1 | Source is a vector (1) or a scalar (0) |
| dst_vec | input | 1 | Destination is a vector (1) or a scalar (0) |
| src_mask | input | MAX_VL | Source predicate, bit k for element k |
| dst_mask | input | MAX_VL | Destination predicate, bit k for element k |
| src_zero | input | 1 | Source zeroing enable |
| dst_zero | input | 1 | Destination zeroing enable |
| vl | input | IDX_W | Element count |
| busy | output | 1 | Move in progress |
| done | output | 1 | High in the last busy cycle of a move |
| rd_en | output | 1 | Source read valid this cycle |
| rd_addr | output | REG_AW | Source register number |
| rd_data | input | DW | Read data, combinational answer to rd_addr |
| wr_en | output | 1 | Destination write this cycle |
| wr_addr | output | REG_AW | Destination register number |
| wr_data | output | DW | Value to write |

## Verification
A source or destination index that is one element off, or a skip that stops one bit early, puts a value in the wrong register or writes a register that should have kept its old contents. The whole register file is compared after each move, so such an error shows when that move ends. A wrong loop end shows in the same move as an extra or missing write, and as a busy period one cycle longer or shorter than the model predicts. A zeroing fault shows as a nonzero value where zero was due, or the reverse, in the register that step addressed.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tpm_state_e;

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_DATA = 2'd1,
        WK_ZERO = 2'd2
    } tpm_wkind_e;

    // What the destination receives for one step.
    function automatic tpm_wkind_e tpm_write_kind(input logic dst_bit, input logic dst_zeroing);
        if (dst_bit)
            return WK_DATA;
        else if (dst_zeroing)
            return WK_ZERO;
        else
            return WK_NONE;
    endfunction

endpackage

// File: rtl/tpm_scan.sv
// Finds the first position at or after 'from' whose mask bit is set,
// bounded by 'limit'. With skipping disabled the position is 'from'.
module tpm_scan #(
    parameter int MAX_VL = 16,
    parameter int IDX_W  = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MAX_VL-1:0] mask,
    input  logic [IDX_W-1:0]  from,
    input  logic [IDX_W-1:0]  limit,
    input  logic              skip_en,
    output logic [IDX_W-1:0]  pos,
    output logic              pbit
);

    always_comb begin
        pos = from;
        if (skip_en) begin
            pos = limit;
            for (int k = MAX_VL - 1; k >= 0; k--) begin
                if (IDX_W'(k) >= from && IDX_W'(k) < limit && mask[k])
                    pos = IDX_W'(k);
            end
        end
    end

    always_comb begin
        pbit = 1'b0;
        for (int k = 0; k < MAX_VL; k++) begin
            if (IDX_W'(k) == pos)
                pbit = mask[k];
        end
    end

    AST_SCAN_HIT: assert property (@(posedge clk) disable iff (rst)
        (skip_en && pos < limit) |-> pbit);            // R2
    AST_SCAN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (skip_en && from <= limit) |-> (pos <= limit && pos >= from)); // R9

endmodule

// File: rtl/tpm_select.sv
// Decides the write kind and the write value for one step.
module tpm_select #(
    parameter int DW = 32
) (
    input  logic                 src_bit,
    input  logic                 dst_bit,
    input  logic                 src_zeroing,
    input  logic                 dst_zeroing,
    input  logic [DW-1:0]        rd_data,
    output tpm_pkg::tpm_wkind_e  kind,
    output logic [DW-1:0]        data
);
    import tpm_pkg::*;

    logic src_blank;

    assign src_blank = src_zeroing && !src_bit;

    always_comb begin
        kind = tpm_write_kind(dst_bit, dst_zeroing);
        data = '0;
        if (kind == WK_DATA && !src_blank)
            data = rd_data;
    end

endmodule

// File: rtl/tpm_move_engine.sv
module tpm_move_engine #(
    parameter int MAX_VL = 16,
    parameter int REG_AW = 5,
    parameter int DW     = 32,
    localparam int IDX_W = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [REG_AW-1:0] src_base,
    input  logic [REG_AW-1:0] dst_base,
    input  logic              src_vec,
    input  logic              dst_vec,
    input  logic [MAX_VL-1:0] src_mask,
    input  logic [MAX_VL-1:0] dst_mask,
    input  logic              src_zero,
    input  logic              dst_zero,
    input  logic [IDX_W-1:0]  vl,
    output logic              busy,
    output logic              done,
    output logic              rd_en,
    output logic [REG_AW-1:0] rd_addr,
    input  logic [DW-1:0]     rd_data,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [DW-1:0]     wr_data
);
    import tpm_pkg::*;

    localparam logic [IDX_W-1:0] VL_CAP = IDX_W'(MAX_VL);

    tpm_state_e        state_q;
    logic [IDX_W-1:0]  i_q, j_q, vl_q;
    logic [REG_AW-1:0] sbase_q, dbase_q;
    logic              svec_q, dvec_q, szero_q, dzero_q;
    logic [MAX_VL-1:0] smask_q, dmask_q;

    logic [IDX_W-1:0]  ii, jj;
    logic              ps, pd, run, fin, step;
    tpm_wkind_e        kind;
    logic [DW-1:0]     sel_data;

    tpm_scan #(.MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_src_scan (
        .clk     (clk),
        .rst     (rst),
        .mask    (smask_q),
        .from    (i_q),
        .limit   (vl_q),
        .skip_en (svec_q && !szero_q),
        .pos     (ii),
        .pbit    (ps)
    );

    tpm_scan #(.MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_dst_scan (
        .clk     (clk),
        .rst     (rst),
        .mask    (dmask_q),
        .from    (j_q),
        .limit   (vl_q),
        .skip_en (dvec_q && !dzero_q),
        .pos     (jj),
        .pbit    (pd)
    );

    tpm_select #(.DW(DW)) u_select (
        .src_bit     (ps),
        .dst_bit     (pd),
        .src_zeroing (szero_q),
        .dst_zeroing (dzero_q),
        .rd_data     (rd_data),
        .kind        (kind),
        .data        (sel_data)
    );

    assign run     = (state_q == ST_RUN);
    assign fin     = (ii >= vl_q) || (jj >= vl_q);
    assign step    = run && !fin;
    assign busy    = run;
    assign done    = run && (fin || !dvec_q);
    assign rd_en   = step;
    assign rd_addr = sbase_q + REG_AW'(ii);
    assign wr_en   = step && (kind != WK_NONE);
    assign wr_addr = dbase_q + REG_AW'(jj);
    assign wr_data = sel_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            i_q     <= '0;
            j_q     <= '0;
            vl_q    <= '0;
            sbase_q <= '0;
            dbase_q <= '0;
            svec_q  <= 1'b0;
            dvec_q  <= 1'b0;
            szero_q <= 1'b0;
            dzero_q <= 1'b0;
            smask_q <= '0;
            dmask_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        i_q     <= '0;
                        j_q     <= '0;
                        vl_q    <= (vl > VL_CAP) ? VL_CAP : vl;
                        sbase_q <= src_base;
                        dbase_q <= dst_base;
                        svec_q  <= src_vec;
                        dvec_q  <= dst_vec;
                        szero_q <= src_zero;
                        dzero_q <= dst_zero;
                        smask_q <= src_mask;
                        dmask_q <= dst_mask;
                    end
                end
                default: begin
                    if (done) begin
                        state_q <= ST_IDLE;
                    end else begin
                        i_q <= svec_q ? ii + IDX_W'(1) : ii;
                        j_q <= jj + IDX_W'(1);
                    end
                end
            endcase
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!wr_en && !rd_en && !done));                   // R1
    AST_DST_MASKED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !pd) |-> (wr_data == '0 && dzero_q));           // R5
    AST_SRC_BLANK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wr_en && szero_q && !ps) |-> (wr_data == '0));           // R6
    AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (ii < vl_q && jj < vl_q));                      // R9
    AST_SCALAR_DST_ONE: assert property (@(posedge clk) disable iff (rst)
        (run && !dvec_q) |=> !busy);                              // R8
    AST_DST_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (run && !done) |=> (busy && j_q > $past(j_q)));           // R7
    AST_SRC_SCALAR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !done && !svec_q) |=> (i_q == '0));               // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (run && !done && start) |=> $stable(vl_q) && $stable(dmask_q)); // R10

endmodule

// File: tb/tb_tpm_move_engine.sv
module tb_tpm_move_engine;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_VL = 16;
    localparam int REG_AW = 5;
    localparam int DW     = 32;
    localparam int IDX_W  = $clog2(MAX_VL + 1);
    localparam int NREG   = 1 << REG_AW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [REG_AW-1:0] src_base = '0, dst_base = '0;
    logic              src_vec = 1'b0, dst_vec = 1'b0;
    logic [MAX_VL-1:0] src_mask = '0, dst_mask = '0;
    logic              src_zero = 1'b0, dst_zero = 1'b0;
    logic [IDX_W-1:0]  vl = '0;
    logic              busy, done, rd_en, wr_en;
    logic [REG_AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0]     rd_data, wr_data;

    logic [DW-1:0] mem [NREG];
    logic [DW-1:0] expm [NREG];

    int n_checks = 0;
    int n_fail   = 0;
    int wr_count = 0;
    int rd_bad   = 0;
    logic [REG_AW-1:0] cur_sb;
    int cur_vl = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tpm_move_engine #(.MAX_VL(MAX_VL), .REG_AW(REG_AW), .DW(DW)) dut (
        .clk(clk), .rst(rst), .start(start),
        .src_base(src_base), .dst_base(dst_base),
        .src_vec(src_vec), .dst_vec(dst_vec),
        .src_mask(src_mask), .dst_mask(dst_mask),
        .src_zero(src_zero), .dst_zero(dst_zero), .vl(vl),
        .busy(busy), .done(done), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    assign rd_data = mem[rd_addr];

    // Register file model: write committed mid-cycle, read sees it next step.
    always @(negedge clk) begin
        if (wr_en) begin
            mem[wr_addr] = wr_data;
            wr_count++;
        end
        if (rd_en) begin
            if (((int'(rd_addr) - int'(cur_sb) + NREG) % NREG) >= cur_vl)
                rd_bad++;
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model of one move; fills expm, returns writes and busy cycles.
    task automatic model(input int sb, input int db, input bit sv, input bit dv,
                         input logic [MAX_VL-1:0] sm, input logic [MAX_VL-1:0] dm,
                         input bit sz, input bit dz, input int vlen,
                         output int nw, output int cyc);
        int i = 0, j = 0, ii, jj;
        logic [DW-1:0] v;
        for (int r = 0; r < NREG; r++) expm[r] = mem[r];
        nw = 0; cyc = 0;
        if (vlen > MAX_VL) vlen = MAX_VL;
        forever begin
            cyc++;
            ii = i; jj = j;
            if (sv && !sz) while (ii < vlen && !sm[ii]) ii++;
            if (dv && !dz) while (jj < vlen && !dm[jj]) jj++;
            if (ii >= vlen || jj >= vlen) break;
            if (dm[jj]) begin
                v = (sz && !sm[ii]) ? '0 : expm[(sb + ii) % NREG];
                expm[(db + jj) % NREG] = v;
                nw++;
            end else if (dz) begin
                expm[(db + jj) % NREG] = '0;
                nw++;
            end
            i = sv ? ii + 1 : ii;
            if (dv) j = jj + 1;
            else break;
        end
    endtask

    task automatic run_case(input string tag, input int sb, input int db,
                            input bit sv, input bit dv,
                            input logic [MAX_VL-1:0] sm, input logic [MAX_VL-1:0] dm,
                            input bit sz, input bit dz, input int vlen, input bit poke);
        int nw, ecyc, cyc = 0, guard = 0, mism = 0;
        for (int r = 0; r < NREG; r++) mem[r] = $urandom | 32'h1;
        model(sb, db, sv, dv, sm, dm, sz, dz, vlen, nw, ecyc);
        wr_count = 0; rd_bad = 0;
        cur_sb = REG_AW'(sb); cur_vl = (vlen > MAX_VL) ? MAX_VL : vlen;
        @(negedge clk);
        src_base = REG_AW'(sb); dst_base = REG_AW'(db);
        src_vec = sv; dst_vec = dv; src_mask = sm; dst_mask = dm;
        src_zero = sz; dst_zero = dz; vl = IDX_W'(vlen); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        forever begin
            if (busy) cyc++;
            if (done || guard > 100) break;
            if (poke && cyc == 1) begin
                // foreign configuration while busy (R10)
                src_mask = ~sm; dst_mask = ~dm; vl = IDX_W'(MAX_VL);
                dst_vec = ~dv; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            guard++;
            @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
        check({tag, " timeout"}, guard > 100, 0);
        for (int r = 0; r < NREG; r++) if (mem[r] !== expm[r]) mism++;
        check({tag, " regfile mismatches"}, mism, 0);
        check({tag, " write count"}, wr_count, nw);
        check({tag, " busy cycles"}, cyc, ecyc);
        check({tag, " R9 out-of-range reads"}, rd_bad, 0);
        check({tag, " R1 idle after move"}, {busy, done, wr_en, rd_en}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        $display("FAIL watchdog expired actual=running expected=finished");
        n_checks++; n_fail++;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset outputs", {busy, done, wr_en, rd_en}, 0);

        // Directed corners
        run_case("R2 source skip",       0, 16, 1, 1, 16'b1010_0110_0101_0011, 16'hFFFF, 0, 0, 16, 0);
        run_case("R3 dest skip",         0, 16, 1, 1, 16'hFFFF, 16'b0110_1001_1100_0101, 0, 0, 16, 0);
        run_case("R4 plain copy",        2, 20, 1, 1, 16'hFFFF, 16'hFFFF, 0, 0, 9, 0);
        run_case("R5 dest zeroing",      0, 16, 1, 1, 16'hFFFF, 16'b0000_1111_0011_0101, 0, 1, 16, 0);
        run_case("R6 source zeroing",    0, 16, 1, 1, 16'b0011_0000_1010_1100, 16'hFFFF, 1, 0, 16, 0);
        run_case("R6 both zeroing",      4, 20, 1, 1, 16'h0F0F, 16'h3C3C, 1, 1, 12, 0);
        run_case("R7 scalar source",     7, 16, 0, 1, 16'h0001, 16'h00FF, 0, 0, 8, 0);
        run_case("R7 scalar src zeroed", 7, 16, 0, 1, 16'h0000, 16'hFFFF, 1, 0, 6, 0);
        run_case("R8 scalar dest",       0, 30, 1, 0, 16'b0000_0000_0010_0000, 16'h0001, 0, 0, 16, 0);
        run_case("R8 scalar dest zero",  0, 30, 1, 0, 16'hFFFF, 16'h0000, 0, 1, 16, 0);
        run_case("R8 scalar dest none",  0, 30, 1, 0, 16'hFFFF, 16'h0000, 0, 0, 16, 0);
        run_case("R9 vl zero",           0, 16, 1, 1, 16'hFFFF, 16'hFFFF, 0, 1, 0, 0);
        run_case("R9 source runs out",   0, 16, 1, 1, 16'h0003, 16'hFFFF, 0, 0, 16, 0);
        run_case("R9 skip stops at vl",  0, 16, 1, 1, 16'hFF00, 16'hFFFF, 0, 0, 6, 0);
        run_case("R9 wrap registers",    28, 26, 1, 1, 16'hFFFF, 16'hFFFF, 0, 0, 10, 0);
        run_case("R10 start while busy", 0, 16, 1, 1, 16'h5555, 16'h3333, 0, 0, 16, 1);

        // Random moves over all four zeroing combinations
        for (int n = 0; n < 400; n++) begin
            run_case("R4 random", int'($urandom_range(0, NREG-1)), int'($urandom_range(0, NREG-1)),
                     bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 3) != 0),
                     MAX_VL'($urandom), MAX_VL'($urandom),
                     bit'(n[0]), bit'(n[1]), int'($urandom_range(0, MAX_VL)),
                     bit'($urandom_range(0, 7) == 0));
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule